// File: doc/BRIEF.md
# Buck Soft-Start and Protection Sequencer

This block is the control state machine of a synchronous step-down regulator. It works at the rate of the switching cycle. A one-clock `tick` pulse marks each switching period. When the supply is good and the current-limit threshold has been programmed, the block ramps a digital reference code from zero to full scale. It then holds that code while the converter regulates.

The block also decides whether the high-side and low-side drivers may follow the PWM.

- **Pre-biased output.** During the ramp, the low side stays masked until the high side has switched for the first time. This lets the converter start into a pre-charged output without pulling current back out of it.
- **Overcurrent.** A repeated overcurrent turns both gates off and holds them off for a fixed interval. If the fault struck during the ramp, the unused ramp time is added to that interval. A fresh soft-start then follows.
- **Undervoltage.** Once the ramp has finished, an undervoltage takes the same fixed off-time and then restarts.
- **Overvoltage.** An overvoltage overrides everything else. It forces the low side on and the high side off for as long as the condition lasts.
- **External disable.** A disable request must persist for a qualification interval before it takes effect. Releasing it restarts the ramp.

Top module: `buck_ss_seq`

## Requirements
- R1: While `uvlo_ok` or `prog_done` is low after reset, `ref_code` is 0 and `hs_en`, `ls_en` and `ls_force` are 0. Once both are high, soft-start begins on the next clock: `hs_en` is 1 and `ref_code` is 0.
- R2: After k ticks of soft-start (k < SS_LEN = REF_MAX·2^STEP_LOG2), `ref_code` equals k >> STEP_LOG2. After SS_LEN ticks, `ref_code` equals REF_MAX and both enables are 1 (regulation).
- R3: An overcurrent trip occurs when `oc_evt` is high on two consecutive ticks during soft-start or regulation. An isolated event has no effect. A trip clears both enables and the reference.
  - In regulation, the gates stay off for HOLD_TICKS ticks.
  - In soft-start, they stay off for HOLD_TICKS + (SS_LEN − e) ticks, where e is the number of ramp ticks completed before the tripping tick.
  - A new soft-start follows in both cases.
- R4: In regulation, `fb_uv` turns both gates off for HOLD_TICKS ticks, after which a new soft-start begins. During soft-start, `fb_uv` has no effect.
- R5: Whenever `uvlo_ok` and `prog_done` are high, `fb_ov` gives `ls_force`=1, `hs_en`=0 and `ls_en`=0 in the same cycle, in every state, including the fault off-time.
- R6: During soft-start, `ls_en` stays 0 until the clock after `hs_switched` is seen high. If the high side never switches, `ls_en` becomes 1 when regulation begins.
- R7: `dis_req` held high across DIS_TICKS ticks turns both gates off and sets `ref_code` to 0. A shorter request has no effect. Releasing `dis_req` starts a new soft-start on the next clock.
- R8: A low `uvlo_ok` returns the block to its idle state on the next clock, with all outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-clock pulse per switching period |
| uvlo_ok | input | 1 | Supply above the lockout threshold |
| prog_done | input | 1 | Current-limit threshold programming finished |
| oc_evt | input | 1 | Overcurrent seen in this switching period, sampled on `tick` |
| fb_uv | input | 1 | Feedback below the undervoltage limit |
| fb_ov | input | 1 | Feedback above the overvoltage limit |
| dis_req | input | 1 | External disable request |
| hs_switched | input | 1 | High-side switch has turned on |
| ref_code | output | REF_W | Reference code for the error amplifier |
| hs_en | output | 1 | High side may follow the PWM |
| ls_en | output | 1 | Low side may follow the PWM |
| ls_force | output | 1 | Low side forced on, high side forced off |

## Verification
Each response has a known delay, and the bench samples at the falling edge just after that delay.

| Stimulus | When the result appears |
|---|---|
| Ramp, overcurrent and hold-off counting | One clock after the tick edge that causes it |
| Overvoltage override | Within the same cycle as the input |
| Pre-bias unmasking, undervoltage trip, release of disable, supply loss | One clock after the input |
| Disable qualification | Two clocks after the qualifying tick (counter, then state) |

The bench sends each tick as a one-clock pulse followed by two idle clocks, and reads the outputs only after that. This way every registered path has settled by the time it is read. Overcurrent off-times are swept over every ramp position at which a trip can land, and the bench checks both the last dark tick and the first tick of the new ramp.

// File: rtl/buck_ss_seq.sv
module buck_ss_seq #(
  parameter int REF_W      = 8,
  parameter int REF_MAX    = 200,
  parameter int STEP_LOG2  = 3,
  parameter int HOLD_TICKS = 2048,
  parameter int DIS_TICKS  = 4500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             uvlo_ok,
  input  logic             prog_done,
  input  logic             oc_evt,
  input  logic             fb_uv,
  input  logic             fb_ov,
  input  logic             dis_req,
  input  logic             hs_switched,
  output logic [REF_W-1:0] ref_code,
  output logic             hs_en,
  output logic             ls_en,
  output logic             ls_force
);
  localparam int SS_LEN = REF_MAX << STEP_LOG2;
  localparam int CW     = $clog2(HOLD_TICKS + SS_LEN + 1);
  localparam int DW     = $clog2(DIS_TICKS + 1);

  typedef enum logic [2:0] {S_OFF, S_SOFT, S_RUN, S_HOLD, S_DIS} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dis_cnt;
  logic          oc_prev, hs_seen;

  wire           active  = (st == S_SOFT) || (st == S_RUN);
  wire           armed   = uvlo_ok && prog_done;
  wire           oc_trip = active && tick && oc_evt && oc_prev;
  wire           dis_hit = dis_req && (dis_cnt == DW'(DIS_TICKS));
  wire           ss_last = tick && (cnt == CW'(SS_LEN - 1));
  wire [CW-1:0]  ss_rem  = CW'(SS_LEN) - cnt;
  wire [CW-1:0]  cnt_sh  = cnt >> STEP_LOG2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF; cnt <= '0; hs_seen <= 1'b0;
    end else if (!uvlo_ok) begin
      st <= S_OFF; cnt <= '0; hs_seen <= 1'b0;
    end else begin
      case (st)
        S_OFF:
          if (prog_done) begin st <= S_SOFT; cnt <= '0; hs_seen <= 1'b0; end
        S_SOFT:
          if (dis_hit) st <= S_DIS;
          else if (oc_trip) begin st <= S_HOLD; cnt <= CW'(HOLD_TICKS) + ss_rem; end
          else begin
            if (hs_switched) hs_seen <= 1'b1;
            if (ss_last) begin st <= S_RUN; cnt <= '0; end
            else if (tick) cnt <= cnt + 1'b1;
          end
        S_RUN:
          if (dis_hit) st <= S_DIS;
          else if (oc_trip || fb_uv) begin st <= S_HOLD; cnt <= CW'(HOLD_TICKS); end
        S_HOLD:
          if (dis_hit) st <= S_DIS;
          else if (tick) begin
            if (cnt == CW'(1)) begin st <= S_SOFT; cnt <= '0; hs_seen <= 1'b0; end
            else cnt <= cnt - 1'b1;
          end
        default:
          if (!dis_req) begin st <= S_SOFT; cnt <= '0; hs_seen <= 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                oc_prev <= 1'b0;
    else if (!active || !uvlo_ok) oc_prev <= 1'b0;
    else if (tick)             oc_prev <= oc_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  dis_cnt <= '0;
    else if (!dis_req || !uvlo_ok) dis_cnt <= '0;
    else if (tick && !dis_hit)   dis_cnt <= dis_cnt + 1'b1;
  end

  assign ls_force = armed && fb_ov;
  assign hs_en    = !ls_force && active;
  assign ls_en    = !ls_force && ((st == S_RUN) || (st == S_SOFT && hs_seen));
  assign ref_code = (st == S_RUN)  ? REF_W'(REF_MAX) :
                    (st == S_SOFT) ? REF_W'(cnt_sh) : '0;

  assert_ref_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_code <= REF_W'(REF_MAX));
  assert_ref_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SOFT && $past(st) == S_SOFT) |-> ref_code >= $past(ref_code));
  assert_hold_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && $past(st) != S_HOLD) |-> ($past(oc_evt && tick) || $past(fb_uv)));
  assert_ov_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ls_force |-> (!hs_en && !ls_en));
  assert_prebias_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SOFT && $past(st) == S_SOFT && !ls_force && !$past(ls_force) && $rose(ls_en))
      |-> $past(hs_switched));
  assert_uvlo_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_ok |=> (!hs_en && !ls_en && ref_code == '0));
endmodule

// File: tb/buck_ss_seq_tb.sv
module buck_ss_seq_tb_top;
  localparam int RW = 4, RM = 6, SL = 1, HT = 8, DT = 5;
  localparam int SS = RM << SL;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, uvlo_ok = 1'b0, prog_done = 1'b0;
  logic oc_evt = 1'b0, fb_uv = 1'b0, fb_ov = 1'b0, dis_req = 1'b0, hs_switched = 1'b0;
  logic [RW-1:0] ref_code;
  logic hs_en, ls_en, ls_force;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  buck_ss_seq #(.REF_W(RW), .REF_MAX(RM), .STEP_LOG2(SL), .HOLD_TICKS(HT), .DIS_TICKS(DT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uvlo_ok(uvlo_ok), .prog_done(prog_done),
    .oc_evt(oc_evt), .fb_uv(fb_uv), .fb_ov(fb_ov), .dis_req(dis_req),
    .hs_switched(hs_switched), .ref_code(ref_code), .hs_en(hs_en), .ls_en(ls_en),
    .ls_force(ls_force));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tk(input logic oc);
    @(negedge clk); tick = 1'b1; oc_evt = oc;
    @(negedge clk); tick = 1'b0; oc_evt = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  function automatic int st3();
    return {29'd0, hs_en, ls_en, ls_force};
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", st3(), 0);
    chk("R1 reset ref", int'(ref_code), 0);

    uvlo_ok = 1'b1;
    repeat (3) tk(1'b0);
    chk("R1 idle without prog_done", st3(), 0);
    prog_done = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 soft-start entry", st3(), 3'b100);

    for (int k = 1; k <= SS; k++) begin
      if (k == 3) fb_uv = 1'b1;
      tk(1'b0);
      if (k < SS) begin
        chk("R2 ramp ref", int'(ref_code), k >> SL);
        chk("R6 ls masked in ramp", st3(), 3'b100);
      end else begin
        chk("R2 full scale", int'(ref_code), RM);
        chk("R6 ls enabled at run", st3(), 3'b110);
      end
      if (k == 5) begin
        fb_uv = 1'b0;
        chk("R4 uv ignored in soft-start", int'(hs_en), 1);
      end
    end

    tk(1'b1); tk(1'b0); tk(1'b1); tk(1'b0);
    chk("R3 isolated oc no trip", st3(), 3'b110);

    @(negedge clk); fb_ov = 1'b1;
    #1; chk("R5 ov override in run", st3(), 3'b001);
    @(negedge clk); fb_ov = 1'b0;
    #1; chk("R5 ov released", st3(), 3'b110);

    fb_uv = 1'b1; @(negedge clk); fb_uv = 1'b0; @(negedge clk);
    chk("R4 uv trip", st3(), 0);
    for (int i = 1; i <= HT; i++) begin
      tk(1'b0);
      if (i == 4) begin
        fb_ov = 1'b1; #1;
        chk("R5 ov in hold", st3(), 3'b001);
        fb_ov = 1'b0; #1;
      end
      if (i == HT - 1) chk("R4 off before hold ends", st3(), 0);
      if (i == HT) begin
        chk("R4 restart after hold", st3(), 3'b100);
        chk("R4 restart ref", int'(ref_code), 0);
      end
    end

    for (int j = 0; j <= SS - 2; j++) begin
      int off;
      off = HT + SS - (j + 1);
      for (int n = 0; n < j; n++) tk(1'b0);
      tk(1'b1); tk(1'b1);
      chk("R3 soft oc trip", st3(), 0);
      for (int n = 1; n < off; n++) tk(1'b0);
      chk("R3 soft oc still off", st3(), 0);
      tk(1'b0);
      chk("R3 soft oc restart", st3(), 3'b100);
      chk("R3 soft oc restart ref", int'(ref_code), 0);
    end

    for (int n = 0; n < SS; n++) tk(1'b0);
    chk("R2 regulation again", int'(ref_code), RM);
    tk(1'b1); tk(1'b1);
    chk("R3 run oc trip", st3(), 0);
    for (int n = 1; n < HT; n++) tk(1'b0);
    chk("R3 run oc still off", st3(), 0);
    tk(1'b0);
    chk("R3 run oc restart", st3(), 3'b100);

    repeat (3) tk(1'b0);
    chk("R6 still masked", int'(ls_en), 0);
    hs_switched = 1'b1; @(negedge clk); hs_switched = 1'b0; @(negedge clk);
    chk("R6 ls unmasked after hs switch", st3(), 3'b110);
    chk("R6 ref unchanged", int'(ref_code), 3 >> SL);

    dis_req = 1'b1;
    for (int n = 1; n < DT; n++) tk(1'b0);
    chk("R7 not yet disabled", int'(hs_en), 1);
    tk(1'b0);
    chk("R7 disabled", st3(), 0);
    chk("R7 disabled ref", int'(ref_code), 0);
    dis_req = 1'b0; @(negedge clk); @(negedge clk);
    chk("R7 release restarts", st3(), 3'b100);
    dis_req = 1'b1; tk(1'b0); tk(1'b0); dis_req = 1'b0;
    for (int n = 0; n < DT; n++) tk(1'b0);
    chk("R7 short request ignored", int'(hs_en), 1);
    chk("R7 short request ref", int'(ref_code), 7 >> SL);

    uvlo_ok = 1'b0; @(negedge clk); @(negedge clk);
    chk("R8 uvlo loss", st3(), 0);
    chk("R8 uvlo loss ref", int'(ref_code), 0);
    uvlo_ok = 1'b1; @(negedge clk); @(negedge clk);
    chk("R1 restart after uvlo", st3(), 3'b100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule